// File: doc/BRIEF.md
# Presettable Up Counter with Terminal-Count Reload

This block is a synchronous binary up counter of parameterised width, 8 bits by default. Its count value can be preset from a parallel input bus. Two active-low controls select between loading the preset, holding the count and advancing it. An active-high reset clears the count asynchronously. An active-low terminal-count flag marks the state in which every count bit is 1.

A mode input changes what happens at terminal count. With the mode input low, the counter wraps from all-ones to zero and runs freely. With it high, the terminal-count condition feeds back inside the block: the counter reloads the preset instead of wrapping. Loading a preset P in this mode turns the block into a programmable divider with period 2^W − P clock cycles, and the terminal-count flag goes low for one cycle in each period. The divide ratio can be any value from 2 to 2^W.

Top module: `preset_upcount`

## Requirements
- R1: While `rst_a` is high, `count_q` is 0 and `tc_n` is 1, and reset takes effect without any clock edge.
- R2: A rising edge with `ld_en_n` low sets `count_q` to `preset_val`, whatever `cnt_en_n`, `reload_sel` or the current count are.
- R3: A rising edge with `ld_en_n` high and `cnt_en_n` high leaves `count_q` unchanged, even at all-ones in reload mode.
- R4: `tc_n` is 0 exactly when every bit of `count_q` is 1. It depends on the registered count alone, not on `cnt_en_n`.
- R5: A rising edge with `ld_en_n` high and `cnt_en_n` low increments `count_q` by one when the count is below all-ones.
- R6: With `reload_sel` low, the count-enabled edge that starts from all-ones sets `count_q` to 0.
- R7: With `reload_sel` high, the count-enabled edge that starts from all-ones (`tc_n` low) sets `count_q` to `preset_val`.
- R8: With `reload_sel` high and the count below all-ones, counting is the same as in R5.
- R9: In reload mode with count enabled and a fixed preset P, `tc_n` goes low once every 2^W − P cycles. For W = 8 and P = 0x8F, that is every 113 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_a | input | 1 | Asynchronous reset, active high |
| cnt_en_n | input | 1 | Count enable, active low |
| ld_en_n | input | 1 | Parallel load enable, active low |
| reload_sel | input | 1 | 1: reload preset at terminal count; 0: wrap freely |
| preset_val | input | W | Parallel preset value |
| count_q | output | W | Registered count |
| tc_n | output | 1 | Terminal count, low when count is all-ones |

## Verification
The risky collisions are those where the counter sits at all-ones and a second control also wants the next value. A parallel load can meet the internal reload, and a hold can meet the reload. The bench steers the count to all-ones in reload mode and then, on the critical edge, asserts the load with a preset different from the reload value, or releases the count enable. The load must win in the first case and the count must stay at all-ones in the second. A behavioural reference model checks the count and the flag on every cycle. It also measures the spacing between terminal-count pulses in divider operation.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // operation picked for the next rising edge
   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_HOLD   = 2'd1,
      OP_INC    = 2'd2,
      OP_RELOAD = 2'd3
   } ctr_op_e;

   // how the all-ones detector is built
   localparam int TC_FLAT  = 0;
   localparam int TC_CHUNK = 1;

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
   import ctr_pkg::*;
(
   input  logic    ld_en_n,
   input  logic    cnt_en_n,
   input  logic    reload_sel,
   input  logic    at_top,
   output ctr_op_e op
);

   // priority: load, hold, then reload or increment
   always_comb begin
      if (!ld_en_n)
         op = OP_LOAD;
      else if (cnt_en_n)
         op = OP_HOLD;
      else if (reload_sel && at_top)
         op = OP_RELOAD;
      else
         op = OP_INC;
   end

endmodule

// File: rtl/ctr_tc_detect.sv
module ctr_tc_detect
   import ctr_pkg::*;
#(
   parameter int W        = 8,
   parameter int STYLE    = TC_CHUNK,
   parameter int CHUNK_W  = 4
) (
   input  logic [W-1:0] cnt,
   output logic         all_ones
);

   localparam int NCHUNK = (W + CHUNK_W - 1) / CHUNK_W;

   if (CHUNK_W < 1) begin : g_bad_chunk
      $error("ctr_tc_detect: CHUNK_W must be at least 1");
   end

   if (STYLE == TC_FLAT) begin : g_flat
      assign all_ones = &cnt;
   end else begin : g_chunk
      logic [NCHUNK-1:0] part;
      for (genvar i = 0; i < NCHUNK; i++) begin : g_part
         localparam int LO = i * CHUNK_W;
         localparam int HI = (LO + CHUNK_W > W) ? W - 1 : LO + CHUNK_W - 1;
         assign part[i] = &cnt[HI:LO];
      end
      assign all_ones = &part;
   end

endmodule

// File: rtl/ctr_next_mux.sv
module ctr_next_mux
   import ctr_pkg::*;
#(
   parameter int W = 8
) (
   input  ctr_op_e      op,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] preset,
   output logic [W-1:0] nxt
);

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] inc;
   assign inc = cur + ONE;   // wraps modulo 2^W

   always_comb begin
      unique case (op)
         OP_LOAD, OP_RELOAD: nxt = preset;
         OP_HOLD:            nxt = cur;
         default:            nxt = inc;
      endcase
   end

endmodule

// File: rtl/preset_upcount.sv
module preset_upcount
   import ctr_pkg::*;
#(
   parameter int W        = 8,
   parameter int TC_STYLE = TC_CHUNK,
   parameter int CHUNK_W  = 4
) (
   input  logic         clk,
   input  logic         rst_a,
   input  logic         cnt_en_n,
   input  logic         ld_en_n,
   input  logic         reload_sel,
   input  logic [W-1:0] preset_val,
   output logic [W-1:0] count_q,
   output logic         tc_n
);

   if (W < 2) begin : g_bad_width
      $error("preset_upcount: W must be at least 2");
   end
   if (TC_STYLE != TC_FLAT && TC_STYLE != TC_CHUNK) begin : g_bad_style
      $error("preset_upcount: unknown TC_STYLE");
   end

   logic [W-1:0] cnt_r;
   logic [W-1:0] cnt_d;
   logic         top;
   ctr_op_e      op;

   ctr_tc_detect #(
      .W       (W),
      .STYLE   (TC_STYLE),
      .CHUNK_W (CHUNK_W)
   ) i_tc (
      .cnt      (cnt_r),
      .all_ones (top)
   );

   ctr_op_decode i_dec (
      .ld_en_n    (ld_en_n),
      .cnt_en_n   (cnt_en_n),
      .reload_sel (reload_sel),
      .at_top     (top),
      .op         (op)
   );

   ctr_next_mux #(
      .W (W)
   ) i_mux (
      .op     (op),
      .cur    (cnt_r),
      .preset (preset_val),
      .nxt    (cnt_d)
   );

   always_ff @(posedge clk or posedge rst_a) begin
      if (rst_a)
         cnt_r <= '0;
      else
         cnt_r <= cnt_d;
   end

   assign count_q = cnt_r;
   assign tc_n    = ~top;

endmodule

// File: rtl/preset_upcount_chk.sv
module preset_upcount_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_a,
   input logic         cnt_en_n,
   input logic         ld_en_n,
   input logic         reload_sel,
   input logic [W-1:0] preset_val,
   input logic [W-1:0] count_q,
   input logic         tc_n
);

   // R1
   always @(posedge clk) begin
      if (rst_a) begin
         reset_state_chk: assert (count_q == '0 && tc_n == 1'b1)
            else $error("reset state wrong");
      end
   end

   // R2
   load_wins_chk: assert property (@(posedge clk) disable iff (rst_a)
      !ld_en_n |=> count_q == $past(preset_val));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (rst_a)
      (ld_en_n && cnt_en_n) |=> $stable(count_q));

   // R4
   tc_match_chk: assert property (@(posedge clk) disable iff (rst_a)
      (!tc_n) == ($countones(count_q) == W));

   // R5
   inc_chk: assert property (@(posedge clk) disable iff (rst_a)
      (ld_en_n && !cnt_en_n && tc_n) |=> count_q == $past(count_q) + 1'b1);

   // R6
   wrap_chk: assert property (@(posedge clk) disable iff (rst_a)
      (ld_en_n && !cnt_en_n && !reload_sel && !tc_n) |=> count_q == '0);

   // R7
   reload_chk: assert property (@(posedge clk) disable iff (rst_a)
      (ld_en_n && !cnt_en_n && reload_sel && !tc_n) |=> count_q == $past(preset_val));

endmodule

bind preset_upcount preset_upcount_chk #(.W(W)) i_chk (
   .clk        (clk),
   .rst_a      (rst_a),
   .cnt_en_n   (cnt_en_n),
   .ld_en_n    (ld_en_n),
   .reload_sel (reload_sel),
   .preset_val (preset_val),
   .count_q    (count_q),
   .tc_n       (tc_n)
);

// File: tb/test_preset_upcount.sv
module test_preset_upcount;

   localparam int W      = 8;
   localparam int PERIOD = 10;
   localparam logic [W-1:0] TOP = '1;

   logic         clk = 1'b0;
   logic         rst_a = 1'b0;
   logic         cnt_en_n = 1'b1;
   logic         ld_en_n = 1'b1;
   logic         reload_sel = 1'b0;
   logic [W-1:0] preset_val = '0;
   logic [W-1:0] count_q;
   logic         tc_n;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int last_tc = -1;
   logic [W-1:0] model = '0;

   always #(PERIOD/2) clk = ~clk;

   preset_upcount #(.W(W)) i_preset_upcount (
      .clk        (clk),
      .rst_a      (rst_a),
      .cnt_en_n   (cnt_en_n),
      .ld_en_n    (ld_en_n),
      .reload_sel (reload_sel),
      .preset_val (preset_val),
      .count_q    (count_q),
      .tc_n       (tc_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   endtask

   // drive one cycle at the falling edge, compare after the next rising edge
   task automatic step(input logic ld, input logic ce, input logic rl, input logic [W-1:0] pv);
      logic [W-1:0] exp;
      string        tag;
      ld_en_n = ld; cnt_en_n = ce; reload_sel = rl; preset_val = pv;
      if (!ld) begin exp = pv; tag = "R2"; end
      else if (ce) begin exp = model; tag = "R3"; end
      else if (model == TOP && rl) begin exp = pv; tag = "R7"; end
      else if (model == TOP) begin exp = '0; tag = "R6"; end
      else begin exp = model + 1'b1; tag = rl ? "R8" : "R5"; end
      @(posedge clk);
      @(negedge clk);
      cyc++;
      model = exp;
      check(count_q == model, tag, count_q, model);
      check(tc_n == (model != TOP), "R4", tc_n, model != TOP);
   endtask

   initial begin
      #(PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      @(negedge clk);
      rst_a = 1'b1;
      #1;
      check(count_q == '0, "R1", count_q, 0);
      check(tc_n == 1'b1, "R1", tc_n, 1);
      @(negedge clk);
      rst_a = 1'b0;
      model = '0;

      // load with count disabled and enabled
      step(1'b0, 1'b1, 1'b0, 8'h10);
      step(1'b0, 1'b0, 1'b0, 8'h5A);
      // plain counting
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
      // hold
      step(1'b1, 1'b1, 1'b0, 8'h33);
      step(1'b1, 1'b1, 1'b1, 8'h33);
      // all-ones reached by load, flag independent of count enable
      step(1'b0, 1'b1, 1'b0, TOP);
      step(1'b1, 1'b1, 1'b0, 8'h00);
      // free wrap
      step(1'b0, 1'b0, 1'b0, 8'hFD);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 8'h77);
      // reload mode: hold at all-ones beats reload
      step(1'b0, 1'b0, 1'b1, TOP);
      step(1'b1, 1'b1, 1'b1, 8'h20);
      // load beats reload at all-ones
      step(1'b0, 1'b0, 1'b1, 8'h44);
      check(count_q == 8'h44, "R2", count_q, 8'h44);
      // back to all-ones, then reload with preset
      step(1'b0, 1'b0, 1'b1, 8'hFE);
      step(1'b1, 1'b0, 1'b1, 8'hFE);
      step(1'b1, 1'b0, 1'b1, 8'hC0);
      // divider operation: preset 0x8F gives period 113
      step(1'b0, 1'b0, 1'b1, 8'h8F);
      last_tc = -1;
      for (int i = 0; i < 400; i++) begin
         step(1'b1, 1'b0, 1'b1, 8'h8F);
         if (!tc_n) begin
            if (last_tc >= 0)
               check(cyc - last_tc == 113, "R9", cyc - last_tc, 113);
            last_tc = cyc;
         end
      end
      // async reset mid-cycle during counting
      #2;
      rst_a = 1'b1;
      #1;
      check(count_q == '0, "R1", count_q, 0);
      check(tc_n == 1'b1, "R1", tc_n, 1);
      @(negedge clk);
      rst_a = 1'b0;
      model = '0;
      step(1'b1, 1'b0, 1'b0, 8'h00);
      finish_up();
   end

endmodule